// File: doc/BRIEF.md
# Transition-Signaling Call Element

This block is a clocked model of a delay-insensitive call element that uses two-phase signalling: every event is a single toggle of a level wire, and the direction of the toggle carries no meaning. A set of `K` mutually exclusive request wires share one merged output. Any request event toggles that merged output, and the block remembers which request fired. A separate shared-return wire is the rendezvous input. Once both a request event and a return event have been seen, the response wire that belongs to the remembered request toggles once. The order in which the two events arrive does not matter.

A return event that arrives while no request is outstanding is held in a one-bit flag. It completes together with the next request. The environment has to keep the requests exclusive and keep the events in alternation. A sticky error output records any breach of that protocol, and only a synchronous reset clears it.

Top module: `tcall`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `mrg_lvl` and `proto_err` read 0 and `rsp_lvl` reads all zeros. The input levels present during reset are taken as the reference levels, so they cause no event after release.
- R2: With nothing pending, a change on exactly one bit `i` of `req_lvl` toggles `mrg_lvl` once, at the first rising edge that samples the change.
- R3: After a request on bit `i` has been taken and is pending, a change on `shr_lvl` toggles only `rsp_lvl[i]`, at the first rising edge that samples it. At most one `rsp_lvl` bit changes per cycle.
- R4: A `shr_lvl` change seen while idle is held. The next single request `i` then toggles `mrg_lvl` and `rsp_lvl[i]` on the same edge, and leaves nothing pending.
- R5: A single request change and a `shr_lvl` change sampled on the same edge while idle toggle `mrg_lvl` and `rsp_lvl[i]` together.
- R6: Two or more `req_lvl` bits changing on one edge set `proto_err`. Those requests are ignored: `mrg_lvl` and `rsp_lvl` do not change.
- R7: A `req_lvl` change while a request is pending sets `proto_err`. That change is ignored, and the following return still goes to the originally pending index.
- R8: A second `shr_lvl` change while one is already held sets `proto_err`, and no output level changes.
- R9: Once set, `proto_err` stays at 1 until `rst` is asserted.
- R10: Inputs that hold their levels produce no output changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| req_lvl | input | K | Request wires; a toggle of bit i is a request event i |
| shr_lvl | input | 1 | Shared return wire; a toggle is a return event |
| mrg_lvl | output | 1 | Merged request output; toggles once per accepted request |
| rsp_lvl | output | K | Response wires; bit i toggles when request i meets a return |
| proto_err | output | 1 | Sticky protocol violation flag |

## Verification
Every result is due at the first rising edge that samples the input change: the merge toggle, the response toggle and the error flag each sit exactly one register behind the inputs. A held return event adds no extra delay, because it completes on the same edge as the later request. The bench changes inputs just after a falling edge and reads the outputs at the following falling edge, so each comparison falls in the single cycle its result is due. For the ignored stimuli, the bench checks at that same point that no output moved. It then issues a return event, which shows that the pending index was not disturbed.

// File: rtl/tcall.sv
module tcall #(
  parameter int K = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [K-1:0] req_lvl,
  input  logic         shr_lvl,
  output logic         mrg_lvl,
  output logic [K-1:0] rsp_lvl,
  output logic         proto_err
);

  logic [K-1:0] req_q;
  logic [K-1:0] sel_q;
  logic         shr_q;
  logic         pend_q;
  logic         hold_q;

  logic [K-1:0] req_ev;
  logic         shr_ev;
  logic         any_req;
  logic         multi_req;
  logic         one_req;
  logic         violation;

  assign req_ev    = req_lvl ^ req_q;
  assign shr_ev    = shr_lvl ^ shr_q;
  assign any_req   = req_ev != '0;
  assign multi_req = (req_ev & (req_ev - K'(1))) != '0;
  assign one_req   = any_req && !multi_req;

  // breaches of the environment contract
  assign violation = multi_req
                   || (pend_q && any_req)
                   || (!pend_q && hold_q && shr_ev);

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q     <= req_lvl;
      shr_q     <= shr_lvl;
      mrg_lvl   <= 1'b0;
      rsp_lvl   <= '0;
      proto_err <= 1'b0;
      pend_q    <= 1'b0;
      hold_q    <= 1'b0;
      sel_q     <= '0;
    end else begin
      req_q <= req_lvl;
      shr_q <= shr_lvl;
      if (violation)
        proto_err <= 1'b1;
      if (pend_q) begin
        if (shr_ev) begin
          rsp_lvl <= rsp_lvl ^ sel_q;
          pend_q  <= 1'b0;
        end
      end else if (one_req) begin
        mrg_lvl <= ~mrg_lvl;
        if (shr_ev || hold_q) begin
          rsp_lvl <= rsp_lvl ^ req_ev;
          hold_q  <= 1'b0;
        end else begin
          pend_q <= 1'b1;
          sel_q  <= req_ev;
        end
      end else if (shr_ev) begin
        hold_q <= 1'b1;
      end
    end
  end

  assert_merge_cause_R2: assert property (@(posedge clk) disable iff (rst)
    (mrg_lvl != $past(mrg_lvl)) |-> $past(!pend_q && req_ev != '0));

  assert_rsp_single_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rsp_lvl ^ $past(rsp_lvl)));

  assert_no_hold_while_pending_R4: assert property (@(posedge clk) disable iff (rst)
    pend_q |-> !hold_q);

  assert_pending_request_flagged_R7: assert property (@(posedge clk) disable iff (rst)
    (pend_q && req_ev != '0) |=> proto_err);

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    proto_err |=> proto_err);

endmodule

// File: tb/sim_tcall.sv
module sim_tcall;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] req_lvl = 2'b00;
  logic       shr_lvl = 1'b0;
  logic       mrg_lvl;
  logic [1:0] rsp_lvl;
  logic       proto_err;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  tcall #(.K(2)) u0 (
    .clk(clk), .rst(rst), .req_lvl(req_lvl), .shr_lvl(shr_lvl),
    .mrg_lvl(mrg_lvl), .rsp_lvl(rsp_lvl), .proto_err(proto_err)
  );

  // {req[1:0], shr, exp_mrg, exp_rsp[1:0], exp_err}
  localparam logic [6:0] VEC [10] = '{
    7'b00_0_0_00_0, // R10 steady
    7'b01_0_1_00_0, // R2 request 0
    7'b01_0_1_00_0, // R10 steady while pending
    7'b01_1_1_01_0, // R3 return to index 0
    7'b11_1_0_01_0, // R2 request 1
    7'b11_0_0_11_0, // R3 return to index 1
    7'b11_1_0_11_0, // R4 early return held
    7'b10_1_1_10_0, // R4 request 0 completes with held return
    7'b00_0_0_00_0, // R5 request 1 and return together
    7'b00_0_0_00_0  // R10 steady
  };

  task automatic check(string tag, logic em, logic [1:0] er, logic ee);
    total++;
    if (mrg_lvl !== em || rsp_lvl !== er || proto_err !== ee) begin
      bad++;
      $display("FAIL %s: got mrg=%b rsp=%b err=%b, expected mrg=%b rsp=%b err=%b",
               tag, mrg_lvl, rsp_lvl, proto_err, em, er, ee);
    end
  endtask

  task automatic step(logic [1:0] r, logic s);
    @(negedge clk);
    req_lvl = r;
    shr_lvl = s;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset(logic [1:0] r, logic s);
    @(negedge clk);
    rst = 1'b1;
    req_lvl = r;
    shr_lvl = s;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 in reset", 1'b0, 2'b00, 1'b0);
    rst = 1'b0;

    for (int i = 0; i < 10; i++) begin
      step(VEC[i][6:5], VEC[i][4]);
      check($sformatf("vector %0d (R2..R5,R10)", i), VEC[i][3], VEC[i][2:1], VEC[i][0]);
    end

    // R7: extra request while pending is flagged and ignored
    step(2'b01, 1'b0);
    check("R7 setup request 0", 1'b1, 2'b00, 1'b0);
    step(2'b11, 1'b0);
    check("R7 request while pending", 1'b1, 2'b00, 1'b1);
    step(2'b11, 1'b1);
    check("R7 return keeps index 0", 1'b1, 2'b01, 1'b1);
    step(2'b11, 1'b1);
    step(2'b11, 1'b1);
    check("R9 error stays set", 1'b1, 2'b01, 1'b1);

    // R1: reset with nonzero input levels gives no event afterwards
    do_reset(2'b10, 1'b1);
    check("R1 after reset", 1'b0, 2'b00, 1'b0);
    step(2'b10, 1'b1);
    check("R1 reset levels are reference", 1'b0, 2'b00, 1'b0);

    // R6: two requests in one cycle
    do_reset(2'b00, 1'b0);
    step(2'b11, 1'b0);
    check("R6 double request", 1'b0, 2'b00, 1'b1);

    // R8: second return while one is held
    do_reset(2'b00, 1'b0);
    step(2'b00, 1'b1);
    check("R8 first return held", 1'b0, 2'b00, 1'b0);
    step(2'b00, 1'b0);
    check("R8 second return", 1'b0, 2'b00, 1'b1);

    // R9: reset clears the error
    do_reset(2'b00, 1'b0);
    check("R9 cleared by reset", 1'b0, 2'b00, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: run did not complete, expected finish before 5000 cycles");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule